// File: doc/BRIEF.md
# Vector Fail-First Length Truncator

This block steps through the elements of a vector operation, one element per clock, up to a vector length captured at a start pulse. For every element whose predicate bit is set it evaluates a condition test on a single condition bit supplied by the datapath. The first element whose test fails ends the walk, and the vector length is cut at that element. Elements with a clear predicate bit are never tested and so can never cut the length.

Options are captured together with the length at the start pulse. An inversion flag selects whether a set bit or a clear bit means "pass". An include flag decides whether the failing element is kept in the new length. A reverse flag walks from the top index down to zero. A zeroing flag and a non-zero flag choose the value that masked-out elements receive: 0 or 1. While the walk runs, the block drives per-element strobes that tell the datapath which element is current, whether it is enabled, and whether it must be overwritten with the fill value. A one-cycle done strobe reports the final length.

Top module: `vff_trunc`

## Requirements
- R1: Condition test: with `inv` low an element passes when `cond_in` is 1; with `inv` high it passes when `cond_in` is 0.
- R2: With `rev` low the elements are presented in the order 0, 1, ..., L-1, one per cycle, starting the cycle after the accepted start. `elem_act` is high in each of those cycles and `elem_idx` carries the index.
- R3: With `rev` high the elements are presented in the order L-1 down to 0, one per cycle.
- R4: The first predicated element that fails its test is the last element presented. With `keep` high and forward order, `vl_out` is the failing index plus 1.
- R5: With `keep` low and forward order, `vl_out` equals the failing index. In the failing cycle `elem_en` is high when `keep` is high and low when `keep` is low.
- R6: In reverse order `vl_out` counts the elements processed: L minus the failing index when `keep` is high, one less when `keep` is low.
- R7: An element whose predicate bit is 0 is not tested, never truncates, and has `elem_en` low. A predicated element has `elem_en` high when it passes.
- R8: If no test fails, `vl_out` equals the captured length (lengths above MAXVL are clamped to MAXVL). `done` rises in the cycle after the last element.
- R9: `done` is high for exactly one cycle. A start that arrives while a walk or its done cycle is in progress is ignored, and the captured length and options stay unchanged.
- R10: A captured length of 0 raises `done` in the cycle after the start, with `vl_out` = 0 and no `elem_act` cycle.
- R11: `elem_zero` is high for an active element whose predicate bit is 0 when `zero_en` is set. `elem_fill` is 1 when both `zero_en` and `snz` are set, and 0 otherwise.
- R12: After reset `done`, `elem_act`, `elem_en`, `elem_zero` are low and `vl_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk; captures the length and all options |
| vl_in | input | LW | Initial vector length |
| rev | input | 1 | Walk from the top index down to 0 |
| inv | input | 1 | Test passes on a clear bit instead of a set bit |
| keep | input | 1 | Count the failing element in the new length |
| zero_en | input | 1 | Zeroing for both source and destination |
| snz | input | 1 | With zeroing, fill masked elements with 1 |
| pred_mask | input | MAXVL | Per-element predicate bits |
| cond_in | input | 1 | Condition bit of the current element |
| elem_act | output | 1 | An element is being presented this cycle |
| elem_idx | output | LW | Index of the current element |
| elem_en | output | 1 | The current element is operated on |
| elem_zero | output | 1 | The current element gets the fill value |
| elem_fill | output | FILL_W | Fill value for masked elements |
| done | output | 1 | One-cycle completion strobe |
| vl_out | output | LW | Final truncated length |

## Verification
Random walks with sparse and dense predicate masks and condition patterns cover both directions, both inversion settings and both include settings. Comparing the index stream and final length against a bench model separates an off-by-one in the fail position from a wrong direction or a wrong include adjustment. Directed cases cover a zero length, a full-length walk with no failure, a failure on the first and the last element, a fully masked vector, and a start held high through a walk. The held start shows whether the captured length was overwritten.

// File: rtl/vff_pkg.sv
package vff_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } vff_state_e;
endpackage

// File: rtl/vff_cond_test.sv
// Per-element condition evaluation and enable/zero/fill generation.
module vff_cond_test #(
   parameter int FILL_W = 1
) (
   input  logic              act,
   input  logic              cond,
   input  logic              inv,
   input  logic              pred,
   input  logic              keep,
   input  logic              zero_en,
   input  logic              snz,
   output logic              fail,
   output logic              en,
   output logic              zero,
   output logic [FILL_W-1:0] fill
);
   logic pass;
   logic fill_one;

   initial begin
      if (FILL_W < 1) $error("vff_cond_test: FILL_W must be at least 1");
   end

   assign pass     = cond ^ inv;
   assign fail     = act & pred & ~pass;
   assign en       = act & pred & (pass | keep);
   assign zero     = act & ~pred & zero_en;
   assign fill_one = zero_en & snz;

   generate
      if (FILL_W == 1) begin : g_fill_bit
         assign fill = fill_one;
      end else begin : g_fill_wide
         assign fill = {{(FILL_W-1){1'b0}}, fill_one};
      end
   endgenerate
endmodule

// File: rtl/vff_elem_seq.sv
// Element index walker, forward or reverse.
module vff_elem_seq #(
   parameter int LW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [LW-1:0] ld_vl,
   input  logic          ld_rev,
   input  logic          adv,
   input  logic          cur_rev,
   input  logic [LW-1:0] cur_vl,
   output logic [LW-1:0] idx,
   output logic          last
);
   localparam logic [LW-1:0] ONE = LW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (load) begin
         idx <= ld_rev ? (ld_vl - ONE) : '0;
      end else if (adv) begin
         idx <= cur_rev ? (idx - ONE) : (idx + ONE);
      end
   end

   assign last = cur_rev ? (idx == '0) : (idx == (cur_vl - ONE));
endmodule

// File: rtl/vff_len_calc.sv
// Truncated length from the failing position.
module vff_len_calc #(
   parameter int LW = 5
) (
   input  logic [LW-1:0] idx,
   input  logic [LW-1:0] vl,
   input  logic          rev,
   input  logic          keep,
   output logic [LW-1:0] fail_len
);
   logic [LW-1:0] kadd;
   logic [LW-1:0] fwd_len;
   logic [LW-1:0] rev_len;

   assign kadd     = {{(LW-1){1'b0}}, keep};
   assign fwd_len  = idx + kadd;
   assign rev_len  = vl - idx - LW'(1) + kadd;
   assign fail_len = rev ? rev_len : fwd_len;
endmodule

// File: rtl/vff_trunc.sv
module vff_trunc
   import vff_pkg::*;
#(
   parameter int MAXVL  = 16,
   parameter int FILL_W = 1,
   localparam int LW    = $clog2(MAXVL + 1),
   localparam int IW    = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LW-1:0]     vl_in,
   input  logic              rev,
   input  logic              inv,
   input  logic              keep,
   input  logic              zero_en,
   input  logic              snz,
   input  logic [MAXVL-1:0]  pred_mask,
   input  logic              cond_in,
   output logic              elem_act,
   output logic [LW-1:0]     elem_idx,
   output logic              elem_en,
   output logic              elem_zero,
   output logic [FILL_W-1:0] elem_fill,
   output logic              done,
   output logic [LW-1:0]     vl_out
);
   localparam logic [LW-1:0] VL_MAX = LW'(MAXVL);

   initial begin
      if (MAXVL < 2) $error("vff_trunc: MAXVL must be at least 2");
   end

   vff_state_e       state_q;
   logic [LW-1:0]    vl_q;
   logic             rev_q, inv_q, keep_q, zen_q, snz_q;
   logic [MAXVL-1:0] mask_q;
   logic [LW-1:0]    vl_out_q;
   logic [LW-1:0]    vl_clamp;
   logic             accept;
   logic             running;
   logic             cur_pred;
   logic             fail;
   logic             last;
   logic [LW-1:0]    idx;
   logic [LW-1:0]    fail_len;

   assign vl_clamp = (vl_in > VL_MAX) ? VL_MAX : vl_in;
   assign accept   = (state_q == ST_IDLE) && start;
   assign running  = (state_q == ST_RUN);
   assign cur_pred = mask_q[idx[IW-1:0]];

   vff_elem_seq #(.LW(LW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .ld_vl   (vl_clamp),
      .ld_rev  (rev),
      .adv     (running),
      .cur_rev (rev_q),
      .cur_vl  (vl_q),
      .idx     (idx),
      .last    (last)
   );

   vff_cond_test #(.FILL_W(FILL_W)) u_test (
      .act     (running),
      .cond    (cond_in),
      .inv     (inv_q),
      .pred    (cur_pred),
      .keep    (keep_q),
      .zero_en (zen_q),
      .snz     (snz_q),
      .fail    (fail),
      .en      (elem_en),
      .zero    (elem_zero),
      .fill    (elem_fill)
   );

   vff_len_calc #(.LW(LW)) u_len (
      .idx      (idx),
      .vl       (vl_q),
      .rev      (rev_q),
      .keep     (keep_q),
      .fail_len (fail_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         vl_q     <= '0;
         rev_q    <= 1'b0;
         inv_q    <= 1'b0;
         keep_q   <= 1'b0;
         zen_q    <= 1'b0;
         snz_q    <= 1'b0;
         mask_q   <= '0;
         vl_out_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  vl_q   <= vl_clamp;
                  rev_q  <= rev;
                  inv_q  <= inv;
                  keep_q <= keep;
                  zen_q  <= zero_en;
                  snz_q  <= snz;
                  mask_q <= pred_mask;
                  if (vl_clamp == '0) begin
                     vl_out_q <= '0;
                     state_q  <= ST_DONE;
                  end else begin
                     state_q  <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (fail) begin
                  vl_out_q <= fail_len;
                  state_q  <= ST_DONE;
               end else if (last) begin
                  vl_out_q <= vl_q;
                  state_q  <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign elem_act = running;
   assign elem_idx = idx;
   assign done     = (state_q == ST_DONE);
   assign vl_out   = vl_out_q;
endmodule

// File: rtl/vff_trunc_chk.sv
module vff_trunc_chk #(
   parameter int MAXVL = 16,
   parameter int LW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          elem_act,
   input logic [LW-1:0] elem_idx,
   input logic          elem_en,
   input logic          elem_zero,
   input logic          done,
   input logic [LW-1:0] vl_out,
   input logic          dir_q
);
   // R9: done lasts one cycle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10: no element presented in the done cycle
   a_r10_no_act_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && elem_act));
   // R7: enable only on an active element
   a_r7_en_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
      elem_en |-> elem_act);
   // R11: zero fill only on an active, disabled element
   a_r11_zero_excl: assert property (@(posedge clk) disable iff (!rst_n)
      elem_zero |-> (elem_act && !elem_en));
   // R8: final length never exceeds the maximum
   a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (vl_out <= LW'(MAXVL)));
   // R2: forward steps by +1
   a_r2_fwd_step: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_act && $past(elem_act) && !dir_q) |-> (elem_idx == $past(elem_idx) + LW'(1)));
   // R3: reverse steps by -1
   a_r3_rev_step: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_act && $past(elem_act) && dir_q) |-> (elem_idx == $past(elem_idx) - LW'(1)));
endmodule

bind vff_trunc vff_trunc_chk #(.MAXVL(MAXVL), .LW(LW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .elem_act  (elem_act),
   .elem_idx  (elem_idx),
   .elem_en   (elem_en),
   .elem_zero (elem_zero),
   .done      (done),
   .vl_out    (vl_out),
   .dir_q     (rev_q)
);

// File: tb/vff_trunc_bench.sv
module vff_trunc_bench;
   localparam int MAXVL = 16;
   localparam int LW    = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [LW-1:0]    vl_in = '0;
   logic             rev = 1'b0, inv = 1'b0, keep = 1'b0, zero_en = 1'b0, snz = 1'b0;
   logic [MAXVL-1:0] pred_mask = '0;
   logic [MAXVL-1:0] cond_vec = '0;
   logic             cond_in;
   logic             elem_act, elem_en, elem_zero, done;
   logic [LW-1:0]    elem_idx, vl_out;
   logic [0:0]       elem_fill;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   assign cond_in = cond_vec[elem_idx[3:0]];

   vff_trunc u_vff_trunc (
      .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .rev(rev),
      .inv(inv), .keep(keep), .zero_en(zero_en), .snz(snz),
      .pred_mask(pred_mask), .cond_in(cond_in), .elem_act(elem_act),
      .elem_idx(elem_idx), .elem_en(elem_en), .elem_zero(elem_zero),
      .elem_fill(elem_fill), .done(done), .vl_out(vl_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // One walk: model computes processing count and final length.
   task automatic run_case(input int vl, input bit r, input bit iv, input bit k,
                           input bit ze, input bit sn, input logic [MAXVL-1:0] m,
                           input logic [MAXVL-1:0] cv, input bit hold_start);
      int nproc, explen, vle;
      int order[MAXVL];
      vle = (vl > MAXVL) ? MAXVL : vl;
      nproc = 0;
      explen = vle;
      for (int kk = 0; kk < vle; kk++) begin
         int i;
         i = r ? (vle - 1 - kk) : kk;
         order[nproc] = i;
         nproc++;
         if (m[i] && (cv[i] == iv)) begin   // R1: fail when bit equals inv
            explen = r ? (vle - i - 1 + int'(k)) : (i + int'(k));
            break;
         end
      end
      @(negedge clk);
      vl_in = LW'(vl); rev = r; inv = iv; keep = k; zero_en = ze; snz = sn;
      pred_mask = m; cond_vec = cv; start = 1'b1;
      for (int n = 1; n <= nproc + 1; n++) begin
         @(negedge clk);
         if (hold_start) begin
            vl_in = LW'(3);  // R9: changed length must be ignored
            pred_mask = ~m;
            rev = ~r;
         end else begin
            start = 1'b0;
         end
         if (n <= nproc) begin
            int i;
            bit pass, expen;
            i = order[n-1];
            pass = (cv[i] != iv);
            expen = m[i] && (pass || k);
            chk(r ? "R3 act" : "R2 act", int'(elem_act), 1);
            chk(r ? "R3 idx" : "R2 idx", int'(elem_idx), i);
            chk(m[i] ? (pass ? "R7 en" : "R5 en") : "R7 en", int'(elem_en), int'(expen));
            chk("R11 zero", int'(elem_zero), int'(!m[i] && ze));
            chk("R11 fill", int'(elem_fill), int'(ze && sn));
            chk("R9 busy", int'(done), 0);
         end else begin
            start = 1'b0;
            chk(vle == 0 ? "R10 done" : "R8 done", int'(done), 1);
            chk(vle == 0 ? "R10 act" : "R8 act", int'(elem_act), 0);
            chk(explen == vle ? "R8 len" : (r ? "R6 len" : (k ? "R4 len" : "R5 len")),
                int'(vl_out), explen);
         end
      end
      @(negedge clk);
      chk("R9 pulse", int'(done), 0);
      chk("R9 idle", int'(elem_act), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int seed;
      seed = 32'h1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      chk("R12 done", int'(done), 0);
      chk("R12 act", int'(elem_act), 0);
      chk("R12 en", int'(elem_en), 0);
      chk("R12 zero", int'(elem_zero), 0);
      chk("R12 len", int'(vl_out), 0);
      rst_n = 1'b1;
      // Directed corner cases
      run_case(0, 0, 0, 1, 0, 0, '1, '1, 0);                  // R10
      run_case(16, 0, 0, 0, 0, 0, '1, '1, 0);                 // R8 full, no fail
      run_case(16, 0, 1, 0, 0, 0, '1, '0, 0);                 // R1 inverted pass
      run_case(8, 0, 0, 1, 0, 0, '1, 16'hFFFE, 0);            // R4 fail at 0 keep
      run_case(8, 0, 0, 0, 0, 0, '1, 16'hFFFE, 0);            // R5 fail at 0 drop
      run_case(8, 1, 0, 1, 0, 0, '1, 16'hFF7F, 0);            // R6 fail at top
      run_case(8, 1, 0, 0, 0, 0, '1, 16'hFFFE, 0);            // R6 fail at 0
      run_case(8, 0, 0, 0, 1, 1, '0, '0, 0);                  // R7 all masked, R11
      run_case(10, 0, 0, 1, 1, 0, 16'h00F0, 16'h0000, 0);     // R7 skip, then fail
      run_case(12, 0, 0, 1, 0, 0, '1, 16'hF7FF, 0);           // fail on last element
      run_case(9, 1, 1, 0, 0, 0, '1, 16'h0020, 1);            // R9 start held
      run_case(20, 0, 0, 1, 0, 0, '1, '1, 0);                 // R8 clamp
      // Random walks
      for (int t = 0; t < 400; t++) begin
         logic [MAXVL-1:0] m, cv;
         int vl;
         vl = int'($urandom_range(0, MAXVL));
         m  = MAXVL'($urandom);
         if ($urandom_range(0, 1) == 1) m = m | MAXVL'($urandom);
         cv = MAXVL'($urandom) | MAXVL'($urandom) | MAXVL'($urandom);
         if ($urandom_range(0, 1) == 1) cv = ~cv;
         run_case(vl, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), m, cv, ($urandom_range(0, 7) == 0));
      end
      finish_run();
   end
endmodule